// File: doc/BRIEF.md
# Dual-Core Package Power-State Coordinator

This block follows the idle state of two processor cores and combines them into one package power state. A core moves into C1, C2 or C3 in one of three ways. It can ask for a C-state with an explicit sub-state hint. It can halt, which gives C1. It can read one of two level registers, which gives C2 or C3. A level read is served entirely inside the block. It becomes an ordinary C-state request whose hint comes from a software-written configuration register. It needs no prior monitor setup, and it never reaches the system bus.

From the two core states the block resolves the package state. Whenever the resolved state newly becomes Stop Grant or Deep Sleep, the block sends the chipset a one-cycle level-read request. Chipset inputs can move a Stop Grant package into Stop Grant Snoop or Sleep. When the clock-stop request is active and a core sees a break event, a pending-break flag is raised. That flag returns both cores to C0 so that the package goes back to Normal. A single-core mode uses core 0 alone.

Top module: `pkg_cstate_coord`

## Requirements
- R1: After reset, both core states are C0, the package state is Normal (code 0), and both hints, the configuration hints, the pending-break flag and the chipset read pulse are all zero.
- R2: Each core state is 2 bits in `core_state` (core 0 in [1:0], core 1 in [3:2]), with C0=0, C1=1, C2=2 and C3=3. A request sets the state to `mw_state` and the hint to `mw_hint` one clock later. A halt sets the state to C1 and leaves the hint unchanged. A wake sets the state to C0 and leaves the hint unchanged.
- R3: A level read with select 0 sets the core to C2 with hint `cfg_hint[HINT_W-1:0]`. A level read with select 1 sets the core to C3 with hint `cfg_hint[2*HINT_W-1:HINT_W]`. A write to the configuration register takes effect at the next clock and applies to level reads from the following cycle onward.
- R4: In dual-core mode, if either core is in C0 or C1 the package is Normal (0). If both cores are in C2, or one is in C2 and the other in C3, the package is Stop Grant (1). If both are in C3 the package is Deep Sleep (4).
- R5: In single-core mode, core 1 is held at C0 from the next clock, its requests and break events are ignored, and the package follows core 0 alone: C0 and C1 give Normal, C2 gives Stop Grant and C3 gives Deep Sleep.
- R6: `cs_lvl_rd` is high for exactly the cycle in which the resolved state first becomes Stop Grant (`cs_lvl_sel`=0) or Deep Sleep (`cs_lvl_sel`=1). It is never high in any other cycle.
- R7: Stop Grant Snoop (2) and Sleep (3) appear only while the resolved state is Stop Grant and the matching chipset input is high. Sleep wins over Snoop.
- R8: `pend_brk` rises one clock after a break event that arrives while `stpclk` is high. It stays high until the clock after `stpclk` falls. A break event while `stpclk` is low has no effect.
- R9: While `pend_brk` is high, both cores are forced to C0 at each clock and all core requests are ignored.
- R10: When several requests reach the same core together, the priority is wake, then level read, then explicit request, then halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_core | input | 1 | 1 = only core 0 is used |
| halt | input | 2 | Per-core halt (enter C1) |
| wake | input | 2 | Per-core return to C0 |
| mw_req | input | 2 | Per-core explicit C-state request |
| mw_state | input | 4 | Requested C-state, 2 bits per core |
| mw_hint | input | 2*HINT_W | Requested sub-state hint per core |
| lvl_rd | input | 2 | Per-core level-register read |
| lvl_sel | input | 2 | Per-core level select: 0 = level 2, 1 = level 3 |
| cfg_we | input | 1 | Configuration hint write enable |
| cfg_hint_in | input | 2*HINT_W | Level-2 hint low half, level-3 hint high half |
| stpclk | input | 1 | Clock-stop request from the chipset, active high |
| brk_evt | input | 2 | Per-core break event |
| cs_snoop | input | 1 | Chipset asks for Stop Grant Snoop |
| cs_sleep | input | 1 | Chipset asks for Sleep |
| core_state | output | 4 | Current C-state of each core |
| core_hint | output | 2*HINT_W | Current hint of each core |
| pkg_state | output | 3 | Package state: 0 Normal, 1 Stop Grant, 2 Stop Grant Snoop, 3 Sleep, 4 Deep Sleep |
| cs_lvl_rd | output | 1 | One-cycle level-read request to the chipset |
| cs_lvl_sel | output | 1 | Level of that request: 0 = level 2, 1 = level 3 |
| pend_brk | output | 1 | Pending break, active high |

## Verification
The bench builds the block with `HINT_W` = 3. With that narrow width, distinct hints can be told apart in the two halves of the configuration register and in both core lanes while the bench stays small. Directed sequences walk through the whole two-core resolution table, both level selects, the chipset overrides and the break handshake. A long random phase then mixes mode changes and colliding requests, so that priority order and the hold on core 1 in single-core mode are exercised against the reference model on every clock.

// File: rtl/pkg_cstate_coord.sv
module pkg_cstate_coord #(
  parameter int HINT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  single_core,
  input  logic [1:0]            halt,
  input  logic [1:0]            wake,
  input  logic [1:0]            mw_req,
  input  logic [3:0]            mw_state,
  input  logic [2*HINT_W-1:0]   mw_hint,
  input  logic [1:0]            lvl_rd,
  input  logic [1:0]            lvl_sel,
  input  logic                  cfg_we,
  input  logic [2*HINT_W-1:0]   cfg_hint_in,
  input  logic                  stpclk,
  input  logic [1:0]            brk_evt,
  input  logic                  cs_snoop,
  input  logic                  cs_sleep,
  output logic [3:0]            core_state,
  output logic [2*HINT_W-1:0]   core_hint,
  output logic [2:0]            pkg_state,
  output logic                  cs_lvl_rd,
  output logic                  cs_lvl_sel,
  output logic                  pend_brk
);
  localparam logic [2:0] PK_NORM = 3'd0, PK_SG = 3'd1, PK_SGS = 3'd2,
                         PK_SLP = 3'd3, PK_DS = 3'd4;

  logic [2*HINT_W-1:0] cfg_q;
  logic [2:0]          res, res_q;
  logic [1:0]          st_a, st_b, st_lo;
  logic                brk_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_hint_in;
  end

  for (genvar c = 0; c < 2; c++) begin : g_core
    localparam bit SECOND = (c == 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        core_state[2*c +: 2]           <= 2'd0;
        core_hint[HINT_W*c +: HINT_W]  <= '0;
      end else if (pend_brk || (SECOND && single_core) || wake[c]) begin
        core_state[2*c +: 2]           <= 2'd0;
      end else if (lvl_rd[c]) begin
        core_state[2*c +: 2]           <= lvl_sel[c] ? 2'd3 : 2'd2;
        core_hint[HINT_W*c +: HINT_W]  <= lvl_sel[c] ? cfg_q[HINT_W +: HINT_W]
                                                     : cfg_q[0 +: HINT_W];
      end else if (mw_req[c]) begin
        core_state[2*c +: 2]           <= mw_state[2*c +: 2];
        core_hint[HINT_W*c +: HINT_W]  <= mw_hint[HINT_W*c +: HINT_W];
      end else if (halt[c]) begin
        core_state[2*c +: 2]           <= 2'd1;
      end
    end
  end

  assign st_a  = core_state[1:0];
  assign st_b  = single_core ? core_state[1:0] : core_state[3:2];
  assign st_lo = (st_a < st_b) ? st_a : st_b;

  always_comb begin
    if (st_lo < 2'd2)                      res = PK_NORM;
    else if (st_a == 2'd3 && st_b == 2'd3) res = PK_DS;
    else                                   res = PK_SG;
  end

  always_comb begin
    pkg_state = res;
    if (res == PK_SG) begin
      if (cs_sleep)      pkg_state = PK_SLP;
      else if (cs_snoop) pkg_state = PK_SGS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= PK_NORM;
    else        res_q <= res;
  end

  assign cs_lvl_rd  = (res != res_q) && (res == PK_SG || res == PK_DS);
  assign cs_lvl_sel = (res == PK_DS);

  assign brk_seen = brk_evt[0] | (brk_evt[1] & ~single_core);

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_brk <= 1'b0;
    else if (!stpclk) pend_brk <= 1'b0;
    else if (brk_seen) pend_brk <= 1'b1;
  end

  assert_normal_if_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_core && (core_state[1:0] < 2'd2 || core_state[3:2] < 2'd2)) |-> pkg_state == PK_NORM);
  assert_core1_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    single_core |=> core_state[3:2] == 2'd0);
  assert_pulse_deep_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl_rd |-> pkg_state != PK_NORM);
  assert_chipset_substates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == PK_SGS || pkg_state == PK_SLP) |-> (cs_snoop || cs_sleep));
  assert_brk_needs_stpclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stpclk |=> !pend_brk);
  assert_brk_wakes_cores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_brk |=> core_state == 4'd0);
endmodule

// File: tb/pkg_cstate_coord_tb.sv
`timescale 1ns/1ps
module pkg_cstate_coord_tb;
  localparam int HW = 3;
  logic clk = 0, rst_n = 0, single_core = 0;
  logic [1:0] halt = 0, wake = 0, mw_req = 0, lvl_rd = 0, lvl_sel = 0, brk_evt = 0;
  logic [3:0] mw_state = 0;
  logic [2*HW-1:0] mw_hint = 0, cfg_hint_in = 0;
  logic cfg_we = 0, stpclk = 0, cs_snoop = 0, cs_sleep = 0;
  logic [3:0] core_state;
  logic [2*HW-1:0] core_hint;
  logic [2:0] pkg_state;
  logic cs_lvl_rd, cs_lvl_sel, pend_brk;

  int total = 0, bad = 0;
  int ms[2], mh[2], mcfg, mprev;
  bit mpbe;

  always #2 clk = ~clk;

  pkg_cstate_coord #(.HINT_W(HW)) u_dut (.*);

  function automatic int resolve(int a, int b, bit sc);
    if (sc) begin
      if (a == 3) return 4;
      if (a == 2) return 1;
      return 0;
    end
    if (a <= 1 || b <= 1) return 0;
    if (a == 3 && b == 3) return 4;
    return 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int r;
    bit force0;
    if (!rst_n) begin
      ms = '{0, 0}; mh = '{0, 0}; mcfg = 0; mpbe = 0; mprev = 0;
      return;
    end
    mprev = resolve(ms[0], ms[1], single_core);
    force0 = mpbe;
    for (int c = 0; c < 2; c++) begin
      if (force0 || (c == 1 && single_core) || wake[c]) ms[c] = 0;
      else if (lvl_rd[c]) begin
        ms[c] = lvl_sel[c] ? 3 : 2;
        mh[c] = lvl_sel[c] ? (mcfg >> HW) : (mcfg % (1 << HW));
      end else if (mw_req[c]) begin
        ms[c] = mw_state[2*c +: 2];
        mh[c] = mw_hint[HW*c +: HW];
      end else if (halt[c]) ms[c] = 1;
    end
    if (cfg_we) mcfg = cfg_hint_in;
    if (!stpclk) mpbe = 0;
    else if (brk_evt[0] || (brk_evt[1] && !single_core)) mpbe = 1;
  endtask

  task automatic compare_all();
    int r, p;
    bit pul;
    r = resolve(ms[0], ms[1], single_core);
    p = r;
    if (r == 1 && cs_sleep) p = 3;
    else if (r == 1 && cs_snoop) p = 2;
    pul = (r != mprev) && (r == 1 || r == 4);
    chk("R2 core0 state", core_state[1:0], ms[0]);
    chk("R2 core1 state", core_state[3:2], ms[1]);
    chk("R3 core0 hint", core_hint[0 +: HW], mh[0]);
    chk("R3 core1 hint", core_hint[HW +: HW], mh[1]);
    chk("R4 package state", pkg_state, p);
    chk("R6 chipset pulse", cs_lvl_rd, pul);
    if (pul) chk("R6 chipset level", cs_lvl_sel, r == 4);
    chk("R8 pending break", pend_brk, mpbe);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    halt = 0; wake = 0; mw_req = 0; lvl_rd = 0; cfg_we = 0; brk_evt = 0;
  endtask

  task automatic mw(int c, int s, int h);
    mw_req[c] = 1; mw_state[2*c +: 2] = s[1:0]; mw_hint[HW*c +: HW] = h[HW-1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    chk("R1 reset core state", core_state, 0);
    chk("R1 reset package", pkg_state, 0);
    chk("R1 reset pend", pend_brk, 0);
    chk("R1 reset pulse", cs_lvl_rd, 0);
    chk("R1 reset hints", core_hint, 0);
    // R2 explicit request and halt
    mw(0, 2, 5); halt[1] = 1; tick();
    chk("R2 core0 C2", core_state[1:0], 2);
    chk("R2 core1 halted C1", core_state[3:2], 1);
    chk("R4 C2/C1 normal", pkg_state, 0);
    mw(1, 3, 6); tick();
    chk("R4 C2/C3 stop grant", pkg_state, 1);
    chk("R6 pulse at stop grant", cs_lvl_rd, 1);
    chk("R6 level 2 select", cs_lvl_sel, 0);
    tick();
    chk("R6 pulse one cycle", cs_lvl_rd, 0);
    cs_sleep = 1; cs_snoop = 1; tick();
    chk("R7 sleep wins", pkg_state, 3);
    cs_sleep = 0; tick();
    chk("R7 snoop", pkg_state, 2);
    // R3 level read with configured hint
    cfg_we = 1; cfg_hint_in = {3'd4, 3'd2}; tick();
    lvl_rd[0] = 1; lvl_sel[0] = 1; tick();
    chk("R3 level3 state", core_state[1:0], 3);
    chk("R3 level3 hint", core_hint[0 +: HW], 4);
    chk("R4 both C3 deep sleep", pkg_state, 4);
    chk("R7 snoop ignored in deep", pkg_state, 4);
    chk("R6 deep pulse sel", cs_lvl_sel, 1);
    cs_snoop = 0;
    lvl_rd[1] = 1; lvl_sel[1] = 0; tick();
    chk("R3 level2 hint", core_hint[HW +: HW], 2);
    // R8 break without stpclk ignored
    brk_evt = 2'b11; tick();
    chk("R8 no stpclk no pend", pend_brk, 0);
    stpclk = 1; brk_evt[1] = 1; tick();
    chk("R8 pend raised", pend_brk, 1);
    mw(0, 3, 1); tick();
    chk("R9 cores forced C0", core_state, 0);
    chk("R9 package normal", pkg_state, 0);
    stpclk = 0; tick();
    chk("R8 pend cleared", pend_brk, 0);
    // R10 priority
    wake[0] = 1; lvl_rd[0] = 1; mw(0, 2, 7); tick();
    chk("R10 wake first", core_state[1:0], 0);
    lvl_rd[0] = 1; lvl_sel[0] = 0; mw(0, 3, 7); halt[0] = 1; tick();
    chk("R10 level read over request", core_state[1:0], 2);
    mw(0, 3, 1); halt[0] = 1; tick();
    chk("R10 request over halt", core_state[1:0], 3);
    // R5 single-core
    single_core = 1; mw(1, 3, 3); tick();
    chk("R5 core1 ignored", core_state[3:2], 0);
    chk("R5 C3 alone deep", pkg_state, 4);
    mw(0, 1, 0); tick();
    chk("R5 C1 alone normal", pkg_state, 0);
    stpclk = 1; brk_evt[1] = 1; tick();
    chk("R5 core1 break ignored", pend_brk, 0);
    stpclk = 0; single_core = 0; tick();
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom % 4 == 0) mw(c, $urandom % 4, $urandom % 8);
        if ($urandom % 8 == 0) halt[c] = 1;
        if ($urandom % 10 == 0) wake[c] = 1;
        if ($urandom % 6 == 0) begin lvl_rd[c] = 1; lvl_sel[c] = $urandom % 2; end
        if ($urandom % 30 == 0) brk_evt[c] = 1;
      end
      if ($urandom % 20 == 0) begin cfg_we = 1; cfg_hint_in = $urandom; end
      if ($urandom % 25 == 0) stpclk = ~stpclk;
      if ($urandom % 60 == 0) single_core = ~single_core;
      cs_snoop = ($urandom % 4 == 0);
      cs_sleep = ($urandom % 6 == 0);
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule